// File: doc/BRIEF.md
# Reconfigurable Timer/Event Counter with Capture

This block is a pair of 8-bit counting sections that can run as two separate 8-bit sections or join into one 16-bit section. A section either counts ticks from an 8-bit programmable prescaler (a timer) or counts rising edges seen on an external event pin (an event counter). A two-bit mode input picks one of four combinations: two 8-bit timers, an 8-bit timer beside an 8-bit event counter, a 16-bit prescaled timer, or a 16-bit event counter.

Each section compares its value with a match input. When the section holds its match value, the next count returns it to zero and sets a sticky flag, which software clears with a one-cycle strobe. A rising edge on the capture pin stores the live count of both halves. In the 16-bit modes these two stored bytes form one 16-bit capture word. The mode input acts as the state of the block. Any change to it clears the counters and the prescalers, so a new mode never starts from a partial count left by the old one.

The state machine has four states. MODE_DUAL is code 00, MODE_MIX is 01, MODE_WIDE_TMR is 10 and MODE_WIDE_EVT is 11. From any state, a new value on `mode_sel` causes a transition straight to that state, and the counters and prescalers are cleared on that edge. A synchronous reset loads the state from `mode_sel`.

Top module: `tc_multimode_timer`

## Requirements
- R1: While `rst_n` is low, on each rising clock edge the block clears both counters, both prescalers, both flags and `cap_lo`/`cap_hi` to 0, and it loads the mode state from `mode_sel`.
- R2: A prescaler with division value d (0 to 255) gives one tick every d+1 clock cycles. It starts from zero after reset or after a mode change, and its first tick comes on the (d+1)-th edge.
- R3: Mode 00 gives two independent 8-bit timers. The low section counts ticks of the prescaler set by `pre_lo_div` and the high section counts ticks of the prescaler set by `pre_hi_div`. A section that holds its match value (`match_lo` or `match_hi`) goes back to 0 on its next tick and sets its own flag, so its value after t ticks is t mod (match+1).
- R4: In mode 01 the low section is an 8-bit timer that works as in mode 00, using `pre_lo_div` and `match_lo`. The high section counts rising edges of `ext_evt`, which pass through two synchronising flip-flops, and it uses `match_hi` and `flag_hi`. An edge counts if `ext_evt` stays high for at least 2 cycles and then low for at least 2 cycles.
- R5: Mode 10 gives one 16-bit timer {high,low}. It counts ticks of the `pre_lo_div` prescaler against the match value {`match_hi`,`match_lo`}. The value after t ticks is t mod (match+1). The reload sets `flag_hi`, and `flag_lo` never rises in this mode.
- R6: Mode 11 gives one 16-bit counter of synchronised `ext_evt` rising edges, with no prescaler. It uses the same match, reload and flag rules as mode 10, and the low byte carries into the high byte.
- R7: Each flag stays set until a one-cycle high on `clr_flag_lo` or `clr_flag_hi` clears it. When a flag is set and cleared in the same cycle, the set wins.
- R8: A rising edge on `cap_in`, after two synchronising flip-flops, copies the count of that cycle into {`cap_hi`,`cap_lo`}. The copied value is the one held before any count that happens in the same cycle. The stored value stays until the next capture.
- R9: A change of `mode_sel` zeroes both counters and both prescalers on the next edge, and no count happens on that edge. The flags and the capture registers keep their values across the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | Mode: 00 dual timer, 01 timer+event, 10 16-bit timer, 11 16-bit event |
| pre_lo_div | input | 8 | Division value of the low prescaler (ratio d+1) |
| pre_hi_div | input | 8 | Division value of the high prescaler (mode 00 only) |
| match_lo | input | 8 | Match value of the low section, low byte of the 16-bit match |
| match_hi | input | 8 | Match value of the high section, high byte of the 16-bit match |
| ext_evt | input | 1 | External event input, asynchronous |
| cap_in | input | 1 | Capture trigger, asynchronous, rising edge |
| clr_flag_lo | input | 1 | Write strobe that clears flag_lo |
| clr_flag_hi | input | 1 | Write strobe that clears flag_hi |
| cap_lo | output | 8 | Captured low section |
| cap_hi | output | 8 | Captured high section |
| flag_lo | output | 1 | Sticky match flag of the low section |
| flag_hi | output | 1 | Sticky match flag of the high section or of the 16-bit section |

## Verification
The checker watches four things on every cycle. A set flag stays set unless it is strobed clear without a new match. `flag_lo` never rises in the 16-bit modes. Every capture copies exactly the count of its trigger cycle. A mode change leaves both counters at zero.

Other behaviour shows only in the bench's scenarios, which sweep the division and match values. These are the reload arithmetic t mod (match+1), prescaler ratios up to 256, the carry from the low byte into the high byte, and event counting through the synchroniser. The same holds for the priority of set over clear, and for flags and captures surviving a mode change.

// File: rtl/tc_pkg.sv
package tc_pkg;
    // Operating combinations of the two counting sections.
    typedef enum logic [1:0] {
        MODE_DUAL     = 2'b00,  // two 8-bit prescaled timers
        MODE_MIX      = 2'b01,  // low timer, high event counter
        MODE_WIDE_TMR = 2'b10,  // one 16-bit prescaled timer
        MODE_WIDE_EVT = 2'b11   // one 16-bit event counter
    } tc_mode_e;
endpackage

// File: rtl/tc_edge_sync.sv
// Multi-stage synchroniser followed by a rising-edge detector.
module tc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tc_prescaler.sv
// Programmable divider: one tick every div+1 cycles.
module tc_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    assign tick = (cnt_q == div);

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tc_section.sv
// One counting half: clear has priority, wrap forces zero on a count.
module tc_section #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    input  logic         wrap,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            value <= '0;
        else if (inc) begin
            if (wrap)
                value <= '0;
            else
                value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/tc_multimode_timer.sv
module tc_multimode_timer
    import tc_pkg::*;
#(
    parameter int HALF_W      = 8,
    parameter int PRE_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic [PRE_W-1:0]  pre_lo_div,
    input  logic [PRE_W-1:0]  pre_hi_div,
    input  logic [HALF_W-1:0] match_lo,
    input  logic [HALF_W-1:0] match_hi,
    input  logic              ext_evt,
    input  logic              cap_in,
    input  logic              clr_flag_lo,
    input  logic              clr_flag_hi,
    output logic [HALF_W-1:0] cap_lo,
    output logic [HALF_W-1:0] cap_hi,
    output logic              flag_lo,
    output logic              flag_hi
);
    localparam int NSEC = 2;

    // ---------------- input synchronisers ----------------
    logic evt_rise;
    logic cap_rise;

    tc_edge_sync #(.STAGES(SYNC_STAGES)) u_evt_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_evt),
        .rise (evt_rise)
    );

    tc_edge_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cap_in),
        .rise (cap_rise)
    );

    // ---------------- mode state register ----------------
    tc_mode_e mode_q;
    tc_mode_e mode_d;
    logic     mode_chg;

    assign mode_d   = tc_mode_e'(mode_sel);
    assign mode_chg = (mode_d != mode_q);

    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= mode_d;
        else
            mode_q <= mode_d;
    end

    // ---------------- prescalers ----------------
    logic [PRE_W-1:0] pre_div  [NSEC];
    logic [NSEC-1:0]  pre_tick;

    assign pre_div[0] = pre_lo_div;
    assign pre_div[1] = pre_hi_div;

    for (genvar g = 0; g < NSEC; g++) begin : g_pre
        tc_prescaler #(.W(PRE_W)) u_pre (
            .clk  (clk),
            .rst_n(rst_n),
            .clear(mode_chg),
            .div  (pre_div[g]),
            .tick (pre_tick[g])
        );
    end

    // ---------------- counting sections ----------------
    logic [HALF_W-1:0] sec_val  [NSEC];
    logic [NSEC-1:0]   sec_inc;
    logic [NSEC-1:0]   sec_wrap;

    for (genvar g = 0; g < NSEC; g++) begin : g_sec
        tc_section #(.W(HALF_W)) u_sec (
            .clk  (clk),
            .rst_n(rst_n),
            .clear(mode_chg),
            .inc  (sec_inc[g]),
            .wrap (sec_wrap[g]),
            .value(sec_val[g])
        );
    end

    // ---------------- per-state control ----------------
    logic lo_eq, hi_eq, full_eq, lo_full;
    logic wide_src;
    logic set_lo, set_hi;

    assign lo_eq   = (sec_val[0] == match_lo);
    assign hi_eq   = (sec_val[1] == match_hi);
    assign full_eq = lo_eq & hi_eq;
    assign lo_full = &sec_val[0];

    always_comb begin
        sec_inc  = '0;
        sec_wrap = '0;
        set_lo   = 1'b0;
        set_hi   = 1'b0;
        wide_src = 1'b0;
        unique case (mode_q)
            MODE_DUAL: begin
                sec_inc[0]  = pre_tick[0];
                sec_wrap[0] = lo_eq;
                sec_inc[1]  = pre_tick[1];
                sec_wrap[1] = hi_eq;
                set_lo      = pre_tick[0] & lo_eq;
                set_hi      = pre_tick[1] & hi_eq;
            end
            MODE_MIX: begin
                sec_inc[0]  = pre_tick[0];
                sec_wrap[0] = lo_eq;
                sec_inc[1]  = evt_rise;
                sec_wrap[1] = hi_eq;
                set_lo      = pre_tick[0] & lo_eq;
                set_hi      = evt_rise & hi_eq;
            end
            MODE_WIDE_TMR, MODE_WIDE_EVT: begin
                wide_src    = (mode_q == MODE_WIDE_TMR) ? pre_tick[0] : evt_rise;
                sec_inc[0]  = wide_src;
                sec_wrap[0] = full_eq;
                sec_inc[1]  = wide_src & (full_eq | lo_full);
                sec_wrap[1] = full_eq;
                set_hi      = wide_src & full_eq;
            end
            default: begin
                sec_inc = '0;
            end
        endcase
        // A mode change clears the sections; no count and no flag on that edge.
        if (mode_chg) begin
            set_lo = 1'b0;
            set_hi = 1'b0;
        end
    end

    // ---------------- sticky flags ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_lo <= 1'b0;
            flag_hi <= 1'b0;
        end else begin
            if (set_lo)
                flag_lo <= 1'b1;
            else if (clr_flag_lo)
                flag_lo <= 1'b0;
            if (set_hi)
                flag_hi <= 1'b1;
            else if (clr_flag_hi)
                flag_hi <= 1'b0;
        end
    end

    // ---------------- capture ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_lo <= '0;
            cap_hi <= '0;
        end else if (cap_rise) begin
            cap_lo <= sec_val[0];
            cap_hi <= sec_val[1];
        end
    end
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   mode_sel,
    input logic [1:0]   mode_state,
    input logic [W-1:0] lo_val,
    input logic [W-1:0] hi_val,
    input logic         cap_rise,
    input logic [W-1:0] cap_lo,
    input logic [W-1:0] cap_hi,
    input logic         flag_lo,
    input logic         flag_hi,
    input logic         clr_flag_lo,
    input logic         clr_flag_hi,
    input logic         set_lo
);
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_lo && !clr_flag_lo) |=> flag_lo);

    assert_flag_hi_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_hi && !clr_flag_hi) |=> flag_hi);

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_lo && clr_flag_lo && !set_lo) |=> !flag_lo);

    assert_wide_lo_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_state[1] |=> !$rose(flag_lo));

    assert_capture_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_rise |=> ({cap_hi, cap_lo} == $past({hi_val, lo_val})));

    assert_mode_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != mode_state) |=> (lo_val == '0 && hi_val == '0));
endmodule

bind tc_multimode_timer tc_checker #(.W(HALF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .mode_state (mode_q),
    .lo_val     (sec_val[0]),
    .hi_val     (sec_val[1]),
    .cap_rise   (cap_rise),
    .cap_lo     (cap_lo),
    .cap_hi     (cap_hi),
    .flag_lo    (flag_lo),
    .flag_hi    (flag_hi),
    .clr_flag_lo(clr_flag_lo),
    .clr_flag_hi(clr_flag_hi),
    .set_lo     (set_lo)
);

// File: tb/sim_tc_multimode_timer.sv
`timescale 1ns/1ps
module sim_tc_multimode_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [7:0] pre_lo_div = 8'd0, pre_hi_div = 8'd0;
    logic [7:0] match_lo = 8'd0, match_hi = 8'd0;
    logic       ext_evt = 1'b0, cap_in = 1'b0;
    logic       clr_flag_lo = 1'b0, clr_flag_hi = 1'b0;
    logic [7:0] cap_lo, cap_hi;
    logic       flag_lo, flag_hi;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    tc_multimode_timer u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .pre_lo_div(pre_lo_div), .pre_hi_div(pre_hi_div),
        .match_lo(match_lo), .match_hi(match_hi),
        .ext_evt(ext_evt), .cap_in(cap_in),
        .clr_flag_lo(clr_flag_lo), .clr_flag_hi(clr_flag_hi),
        .cap_lo(cap_lo), .cap_hi(cap_hi),
        .flag_lo(flag_lo), .flag_hi(flag_hi)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int tval(input int n, input int d, input int m);
        return (n / (d + 1)) % (m + 1);
    endfunction

    function automatic int tflag(input int n, input int d, input int m);
        return ((n / (d + 1)) >= (m + 1)) ? 1 : 0;
    endfunction

    task automatic restart(input int md, input int dl, input int dh,
                           input int ml, input int mh);
        @(negedge clk);
        mode_sel = md[1:0];
        pre_lo_div = dl[7:0]; pre_hi_div = dh[7:0];
        match_lo = ml[7:0]; match_hi = mh[7:0];
        ext_evt = 1'b0; cap_in = 1'b0;
        clr_flag_lo = 1'b0; clr_flag_hi = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Wait k edges, trigger a capture, read after it lands (k+3 edges total).
    task automatic capture_after(input int k, output int cap, output int fl, output int fh);
        repeat (k) @(posedge clk);
        @(negedge clk);
        cap_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cap = {cap_hi, cap_lo};
        fl = flag_lo;
        fh = flag_hi;
        cap_in = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_evt = 1'b1;
            repeat (3) @(posedge clk);
            @(negedge clk); ext_evt = 1'b0;
            repeat (3) @(posedge clk);
        end
        repeat (4) @(posedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int cap, fl, fh, n;
        // R3/R2 sweep, mode 00
        for (int d = 0; d < 4; d++) begin
            for (int m = 0; m < 4; m++) begin
                restart(0, d, 3 - d, m, m + 2);
                capture_after(37, cap, fl, fh);
                n = 37 + 2;
                check("R3 lo value", cap & 8'hFF, tval(n, d, m));
                check("R3 hi value", cap >> 8, tval(n, 3 - d, m + 2));
                check("R3 lo flag", fl, tflag(n + 1, d, m));
                check("R3 hi flag", fh, tflag(n + 1, 3 - d, m + 2));
            end
        end
        // R2 widest ratio
        restart(0, 255, 0, 255, 255);
        capture_after(600, cap, fl, fh);
        check("R2 div256 value", cap & 8'hFF, tval(602, 255, 255));
        check("R2 div1 hi value", cap >> 8, tval(602, 0, 255));

        // R1 reset state after a run that left state nonzero
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 cap after reset", {cap_hi, cap_lo}, 0);
        check("R1 flags after reset", {flag_hi, flag_lo}, 0);
        rst_n = 1'b1;

        // R4 mode 01: high counts events
        for (int d = 0; d < 3; d++) begin
            for (int k = 0; k < 4; k++) begin
                int ev;
                ev = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 4 : 9;
                restart(1, d, 0, 5, 6);
                pulses(ev);
                capture_after(0, cap, fl, fh);
                check("R4 event value", cap >> 8, ev % 7);
                check("R4 event flag", fh, (ev >= 7) ? 1 : 0);
            end
        end

        // R5 mode 10: 16-bit prescaled timer
        for (int c = 0; c < 4; c++) begin
            int d, mm, k;
            d  = (c == 0) ? 0 : (c == 1) ? 1 : (c == 2) ? 2 : 0;
            mm = (c == 0) ? 16'h0105 : (c == 1) ? 16'h01FF : (c == 2) ? 16'h00FF : 16'h0300;
            k  = (c == 0) ? 300 : (c == 1) ? 700 : (c == 2) ? 500 : 520;
            restart(2, d, 0, mm & 8'hFF, mm >> 8);
            capture_after(k, cap, fl, fh);
            check("R5 wide value", cap, tval(k + 2, d, mm));
            check("R5 wide flag_hi", fh, tflag(k + 3, d, mm));
            check("R5 flag_lo quiet", fl, 0);
        end

        // R6 mode 11: 16-bit event counter
        restart(3, 0, 0, 8'h30, 8'h01);
        pulses(310);
        capture_after(0, cap, fl, fh);
        check("R6 event wrap value", cap, 310 % 16'h0131);
        check("R6 event flag", fh, 1);
        restart(3, 0, 0, 8'hFF, 8'hFF);
        pulses(260);
        capture_after(0, cap, fl, fh);
        check("R6 carry value", cap, 260);
        check("R6 no flag", fh, 0);

        // R8 capture keeps value with no new trigger
        repeat (10) @(posedge clk);
        @(negedge clk);
        check("R8 capture held", {cap_hi, cap_lo}, 260);

        // R7 clear strobe and set-over-clear
        restart(0, 0, 0, 1, 1);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R7 flag_lo set", flag_lo, 1);
        match_lo = 8'hFF; match_hi = 8'hFF;
        clr_flag_lo = 1'b1;
        @(posedge clk); @(negedge clk);
        clr_flag_lo = 1'b0;
        check("R7 flag_lo cleared", flag_lo, 0);
        check("R7 flag_hi untouched", flag_hi, 1);
        restart(0, 0, 0, 3, 255);
        clr_flag_lo = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R7 set wins", flag_lo, 1);
        @(posedge clk); @(negedge clk);
        check("R7 clear after set", flag_lo, 0);
        clr_flag_lo = 1'b0;

        // R9 mode change clears counters, keeps flags
        restart(0, 0, 0, 3, 255);
        repeat (50) @(posedge clk);
        @(negedge clk);
        mode_sel = 2'b10;
        match_lo = 8'hFF; match_hi = 8'hFF;
        cap_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cap_in = 1'b0;
        check("R9 counter restarted", {cap_hi, cap_lo}, 1);
        check("R9 flag kept", flag_lo, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule